// File: doc/BRIEF.md
# Two-Dimensional 8x8 Cosine Transform Engine

This block turns an 8x8 tile of unsigned 8-bit grey levels into 64 spatial-frequency coefficients. It uses the standard orthonormal definition, F(u,v) = c(u)c(v)/4 · Σm Σn f(m,n) · cos((2m+1)uπ/16) · cos((2n+1)vπ/16), with c(0) = 1/√2 and c(k) = 1 for k > 0. The two sums separate, so the block computes the transform as two 8x8 matrix products:

- The row pass multiplies each row of the tile by the cosine matrix. Its results go into a 64-entry intermediate store.
- The column pass reads that store by column and applies the same matrix again.

A single multiply-accumulate unit does all 1024 products, one per cycle. The cosine matrix is held in signed Q1.14 form with the c(k)/2 factor already folded in.

Pixels arrive one per cycle in raster order over a valid/ready handshake. Once the 64th pixel is taken, the block stops accepting input. It accepts again only when the tile's last coefficient leaves. One tile is in flight at a time. Coefficients come out in raster order of (u,v), each marked by a one-cycle valid pulse, and the 64th is flagged as last. A build-time option subtracts half the pixel range from every pixel before the transform.

Top module: `dct8x8_2d`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: A pixel is taken on each rising edge where in_valid and in_ready are both 1. The k-th pixel taken (k from 0) is f(m,n) with m = k/8 and n = k%8. Cycles with in_valid low may fall between pixels without changing the result.
- R3: in_ready drops after the edge that takes the 64th pixel. It stays low until the cycle in which out_last is 1, and is 1 in that cycle. Pixels offered while in_ready is low are not taken and have no effect on any tile.
- R4: Each coefficient is the value of F(u,v) rounded to the nearest integer, with an error of at most 1. It is given as 12-bit two's complement on out_coef.
- R5: The coefficients leave in the order index = 8·u + v. out_last is 1 only together with the coefficient at index 63.
- R6: The coefficient at index i is presented in the cycle that follows the (520 + 8·i)-th rising edge after the edge that took the 64th pixel. out_valid is never high in two adjacent cycles.
- R7: With the level shift off, a tile in which every pixel is p gives exactly 8·p at index 0 and exactly 0 at the other 63 indices.
- R8: With the level shift on, 128 is subtracted from each pixel before the transform. A constant tile of value p then gives exactly 8·(p − 128) at index 0 and exactly 0 at the other indices.
- R9: No state carries from one tile to the next. A tile sent again after other tiles gives the same 64 coefficients as the first time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel is offered on in_pix |
| in_ready | output | 1 | The block can take a pixel |
| in_pix | input | 8 | Unsigned grey level |
| out_valid | output | 1 | out_coef holds a coefficient this cycle |
| out_last | output | 1 | The coefficient is the last one of the tile |
| out_coef | output | 12 | Signed coefficient F(u,v) |

## Verification
The bench uses constant tiles because every AC term must then cancel exactly. A cosine table whose mirrored entries are not exact negations, or a rounding step biased to one side, leaves small non-zero AC values or moves the DC value off 8·p. Impulses at the corners and in the middle, ramps, a checkerboard and pseudo-random tiles are compared against a floating-point evaluation of the formula. These catch a swapped row/column index in the intermediate store, a wrong cosine entry, or a missing c(0) factor, each of which distorts whole rows or columns of the result. During every busy period the bench keeps offering junk pixels, and it adds idle gaps to the input stream. A design that takes input while busy, or that advances its load address on idle cycles, ruins the next tile. A design that keeps an accumulator or a buffer from one tile to the next fails the repeat-tile comparison.

// File: rtl/dct8x8_2d.sv
module dct8x8_2d #(
  parameter int PIX_W       = 8,
  parameter int OUT_W       = 12,
  parameter int GUARD       = 3,
  parameter bit LEVEL_SHIFT = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [PIX_W-1:0]        in_pix,
  output logic                    out_valid,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_coef
);

  localparam int N      = 8;
  localparam int LG     = $clog2(N);
  localparam int NN     = N * N;
  localparam int CF_W   = 16;
  localparam int FRAC   = 14;
  localparam int PW     = PIX_W + 1;
  localparam int TW     = PIX_W + LG + GUARD + 2;
  localparam int ACC_W  = TW + CF_W + LG;
  localparam int SH1    = FRAC - GUARD;
  localparam int SH2    = FRAC + GUARD;

  localparam logic signed [ACC_W-1:0] HALF1 = ACC_W'(1 << (SH1 - 1));
  localparam logic signed [ACC_W-1:0] HALF2 = ACC_W'(1 << (SH2 - 1));
  localparam logic signed [ACC_W-1:0] OMAX  = ACC_W'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] OMIN  = -OMAX - ACC_W'(1);
  localparam logic signed [PW-1:0]    OFS   = LEVEL_SHIFT ? PW'(1 << (PIX_W - 1)) : '0;

  typedef enum logic [1:0] {S_LOAD, S_ROW, S_COL} state_t;

  state_t                   state;
  logic [2*LG-1:0]          wcnt;
  logic [LG-1:0]            a, b, k;
  logic [PIX_W-1:0]         pbuf [NN];
  logic signed [TW-1:0]     tbuf [NN];
  logic signed [ACC_W-1:0]  acc;

  logic signed [PW-1:0]     xs;
  logic signed [TW-1:0]     opnd;
  logic signed [CF_W-1:0]   cfv;
  logic signed [ACC_W-1:0]  prod, sum, r1, r2;
  logic signed [OUT_W-1:0]  sat;
  logic                     mac_end, tile_end;

  function automatic logic signed [CF_W-1:0] cf(input logic [2:0] f, input logic [2:0] x);
    logic [6:0] p;
    logic [5:0] q;
    logic neg;
    logic signed [CF_W-1:0] mag;
    p   = {3'b0, x, 1'b1} * {4'b0, f};
    q   = (p[4:0] > 5'd16) ? (6'd32 - {1'b0, p[4:0]}) : {1'b0, p[4:0]};
    neg = (q > 6'd8);
    if (neg) q = 6'd16 - q;
    case (q[3:0])
      4'd0:    mag = 16'sd5793;
      4'd1:    mag = 16'sd8035;
      4'd2:    mag = 16'sd7568;
      4'd3:    mag = 16'sd6811;
      4'd4:    mag = 16'sd5793;
      4'd5:    mag = 16'sd4551;
      4'd6:    mag = 16'sd3135;
      4'd7:    mag = 16'sd1598;
      default: mag = 16'sd0;
    endcase
    return neg ? -mag : mag;
  endfunction

  assign in_ready = (state == S_LOAD);
  assign mac_end  = (k == 3'd7);
  assign tile_end = mac_end && (a == 3'd7) && (b == 3'd7);

  assign xs   = $signed({1'b0, pbuf[{a, k}]}) - OFS;
  assign opnd = (state == S_ROW) ? {{(TW-PW){xs[PW-1]}}, xs} : tbuf[{k, b}];
  assign cfv  = (state == S_ROW) ? cf(b, k) : cf(a, k);
  assign prod = opnd * cfv;
  assign sum  = ((k == 3'd0) ? '0 : acc) + prod;
  assign r1   = (sum + HALF1) >>> SH1;
  assign r2   = (sum + HALF2) >>> SH2;
  assign sat  = (r2 > OMAX) ? OMAX[OUT_W-1:0] :
                (r2 < OMIN) ? OMIN[OUT_W-1:0] : r2[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (state == S_LOAD && in_valid) pbuf[wcnt] <= in_pix;
    if (state == S_ROW && mac_end)   tbuf[{a, b}] <= r1[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_LOAD;
      wcnt      <= '0;
      a         <= '0;
      b         <= '0;
      k         <= '0;
      acc       <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_coef  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      case (state)
        S_LOAD: if (in_valid) begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == 6'd63) state <= S_ROW;
        end
        default: begin
          acc <= sum;
          k   <= k + 1'b1;
          if (mac_end) begin
            b <= b + 1'b1;
            if (b == 3'd7) a <= a + 1'b1;
          end
          if (state == S_COL && mac_end) begin
            out_coef  <= sat;
            out_valid <= 1'b1;
            out_last  <= tile_end;
          end
          if (tile_end) state <= (state == S_ROW) ? S_COL : S_LOAD;
        end
      endcase
    end
  end

  assert_busy_blocks_input_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> !in_ready);
  assert_ready_back_at_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> (out_valid && in_ready));
  assert_ready_drops_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> $past(in_valid));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_no_output_while_loading_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !out_last) |-> !out_valid);

endmodule

// File: tb/dct8x8_2d_tb_top.sv
`timescale 1ns/1ps
module dct8x8_2d_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_pix = '0;
  logic rdy0, rdy1, ov0, ov1, ol0, ol1;
  logic signed [11:0] oc0, oc1;

  always #10 clk = ~clk;

  dct8x8_2d #(.LEVEL_SHIFT(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .in_pix(in_pix),
    .out_valid(ov0), .out_last(ol0), .out_coef(oc0));

  dct8x8_2d #(.LEVEL_SHIFT(1'b1)) dut_ls_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .in_pix(in_pix),
    .out_valid(ov1), .out_last(ol1), .out_coef(oc1));

  int nvec = 0;
  int nerr = 0;
  int blk [64];
  int got0 [64];
  int got1 [64];
  int keep [64];
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real refc(int u, int v, int shift);
    real s = 0.0;
    real pi = 3.14159265358979;
    for (int m = 0; m < 8; m++)
      for (int n = 0; n < 8; n++)
        s += (blk[m*8+n] - shift) * $cos((2*m+1)*u*pi/16.0) * $cos((2*n+1)*v*pi/16.0);
    s = s * ((u == 0) ? 1.0/$sqrt(2.0) : 1.0) * ((v == 0) ? 1.0/$sqrt(2.0) : 1.0) / 4.0;
    return s;
  endfunction

  function automatic int rnd(real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  task automatic run_block(input bit gaps);
    int j, idx, e0, e1;
    while (!rdy0) @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      if (gaps && (i % 5 == 2)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pix   = 8'(blk[i]);
      @(negedge clk);
    end
    in_pix = 8'hC3;
    chk(!rdy0 && !rdy1, "R3 ready low after 64th pixel", int'(rdy0), 0);
    j = 0;
    idx = 0;
    while (idx < 64 && j < 1500) begin
      @(negedge clk);
      j++;
      if (ov0) begin
        chk(j == 520 + 8*idx, "R6 coefficient timing", j, 520 + 8*idx);
        chk(ol0 == (idx == 63), "R5 last flag", int'(ol0), int'(idx == 63));
        chk(rdy0 == (idx == 63), "R3 ready while emitting", int'(rdy0), int'(idx == 63));
        chk(ov1 && (ol1 == ol0), "R6 shifted variant in step", int'(ov1), 1);
        got0[idx] = int'(oc0);
        got1[idx] = int'(oc1);
        idx++;
      end
    end
    chk(idx == 64, "R6 coefficient count", idx, 64);
    for (int u = 0; u < 8; u++)
      for (int v = 0; v < 8; v++) begin
        e0 = rnd(refc(u, v, 0));
        e1 = rnd(refc(u, v, 128));
        chk((got0[u*8+v] - e0 <= 1) && (e0 - got0[u*8+v] <= 1),
            $sformatf("R4 F(%0d,%0d) (R2 raster load)", u, v), got0[u*8+v], e0);
        chk((got1[u*8+v] - e1 <= 1) && (e1 - got1[u*8+v] <= 1),
            $sformatf("R8 shifted F(%0d,%0d)", u, v), got1[u*8+v], e1);
      end
  endtask

  task automatic const_block(input int p);
    for (int i = 0; i < 64; i++) blk[i] = p;
    run_block(1'b0);
    chk(got0[0] == 8*p, "R7 DC of constant tile", got0[0], 8*p);
    chk(got1[0] == 8*(p-128), "R8 DC of shifted constant tile", got1[0], 8*(p-128));
    for (int i = 1; i < 64; i++) begin
      chk(got0[i] == 0, "R7 AC of constant tile", got0[i], 0);
      chk(got1[i] == 0, "R8 AC of shifted constant tile", got1[i], 0);
    end
  endtask

  task automatic rand_fill();
    for (int i = 0; i < 64; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      blk[i] = int'(seed[23:16]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy0 && rdy1, "R1 ready after reset", int'(rdy0), 1);
    chk(!ov0 && !ov1, "R1 no valid after reset", int'(ov0), 0);
    chk(!ol0 && !ol1, "R1 no last after reset", int'(ol0), 0);

    const_block(0);
    const_block(1);
    const_block(77);
    const_block(128);
    const_block(200);
    const_block(255);

    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 64; i++) blk[i] = 0;
      blk[(t == 0) ? 0 : (t == 1) ? 29 : 63] = 255;
      run_block(t == 1);
    end

    for (int i = 0; i < 64; i++) blk[i] = (i % 8) * 32;
    run_block(1'b0);
    for (int i = 0; i < 64; i++) blk[i] = (i / 8) * 30 + 10;
    run_block(1'b1);
    for (int i = 0; i < 64; i++) blk[i] = (((i / 8) + (i % 8)) % 2) * 255;
    run_block(1'b0);

    rand_fill();
    for (int i = 0; i < 64; i++) keep[i] = blk[i];
    run_block(1'b1);
    for (int i = 0; i < 64; i++) keep[i] = got0[i];
    for (int r = 0; r < 6; r++) begin
      rand_fill();
      run_block(r[0]);
    end

    seed = 32'h1234_5678;
    rand_fill();
    run_block(1'b0);
    for (int i = 0; i < 64; i++)
      chk(got0[i] == keep[i], "R9 repeated tile matches", got0[i], keep[i]);

    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule